// File: doc/BRIEF.md
# Execute-Only Region Access Filter

This block sits beside a two-bank flash array and judges every access presented to it. Each access names a byte address, a bank, the kind of requester (CPU instruction fetch, CPU data port, DMA engine or debug probe) and an operation (read, write or erase). Every bank owns one execute-only region. Inside that region the only access allowed is an instruction fetch by the CPU. Any other access is refused. A refused access raises a violation pulse and returns zero data instead of the flash word. The filter does not depend on any readout protection level, so it also applies when the chip is unprotected.

Regions are set by reconfiguration requests. Each request names a bank and the inclusive start and end bounds of the region, counted in 8-byte granules. A region with nothing configured takes any request. Once a region is live it may only grow: a request that would move either bound inward is refused and the region stays as it was. A region can be removed only by an external regression event, and only when the preserve input is low. That event clears every region at once.

The verdict and the acknowledgement are both registered and appear one clock after the request is sampled.

Top module: `xo_region_filter`

## Requirements
- R1: One cycle after `accValid` is sampled high, `rspValid` is 1. An access that misses its bank's region is allowed: `rspAllow`=1, `rspViolation`=0, and `rspRdata` equals the `accRdata` that was sampled. In a cycle after `accValid` was low, `rspValid`, `rspAllow`, `rspViolation` and `rspRdata` are all 0.
- R2: An access that hits its bank's region is allowed only when `accMaster`=0 (CPU instruction fetch) and `accOp`=0 (read). The other master codes are 1 (CPU data), 2 (DMA) and 3 (debug). The other operation codes are 1 (write), 2 (erase) and 3 (reserved, handled like a write).
- R3: A denied access gives `rspValid`=1, `rspAllow`=0, `rspViolation`=1 and `rspRdata`=0 for exactly that one response cycle.
- R4: An access is checked only against the region of the bank named by `accBank`. A region in one bank has no effect on accesses to the other bank.
- R5: A region covers granule indices from start to end inclusive, where the granule index is `accAddr >> 3`. The low three address bits never change the verdict.
- R6: A region whose start is greater than its end is disabled and matches no address.
- R7: A request (`cfgValid`) to a region that is not live (cleared, or start > end) is accepted. One cycle later `cfgDone`=1 and `cfgOk`=1, and the new bounds govern accesses sampled from the next cycle on.
- R8: A request to a live region is accepted only if the new start is less than or equal to the current start and the new end is greater than or equal to the current end. Otherwise `cfgOk`=0 (with `cfgDone`=1) and the region is unchanged.
- R9: When `regressEvt`=1 and `preserveKeep`=0, every region is cleared. A request in the same cycle is discarded (`cfgOk`=0). When `preserveKeep`=1, the event has no effect.
- R10: After reset all response and acknowledgement outputs are 0 and no region is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access present this cycle |
| accAddr | input | ADDR_W | Byte address of the access |
| accBank | input | BANK_W | Flash bank of the access |
| accMaster | input | 2 | Requester kind: 0 fetch, 1 CPU data, 2 DMA, 3 debug |
| accOp | input | 2 | Operation: 0 read, 1 write, 2 erase, 3 reserved |
| accRdata | input | DATA_W | Raw data read from the flash array |
| rspValid | output | 1 | Verdict present |
| rspAllow | output | 1 | Access allowed |
| rspViolation | output | 1 | One-cycle violation pulse |
| rspRdata | output | DATA_W | Read data, zero when denied |
| cfgValid | input | 1 | Region reconfiguration request |
| cfgBank | input | BANK_W | Bank whose region is to be set |
| cfgStart | input | ADDR_W-3 | New start granule index |
| cfgEnd | input | ADDR_W-3 | New end granule index |
| cfgDone | output | 1 | Request acknowledged |
| cfgOk | output | 1 | Request accepted and applied |
| regressEvt | input | 1 | Protection regression event |
| preserveKeep | input | 1 | Keep regions across a regression |

## Verification
The filter is first exercised with directed accesses placed just below, on, and just above each region bound, and with the low address bits varied. This separates an inclusive compare from an off-by-one and shows whether granule truncation is done. Every master and operation code is then aimed at a single address inside a region, which shows whether the permission follows the requester kind rather than the address. Shrinking, growing and disabled-bound requests, followed by regressions with the preserve input high and low, are each confirmed by the verdict on a later access. A long mixed random phase then runs overlapping accesses, requests and regressions, including collisions in the same cycle, against the behavioural model.

// File: rtl/xo_pkg.sv
package xo_pkg;

  typedef enum logic [1:0] {
    MST_FETCH    = 2'd0,
    MST_CPU_DATA = 2'd1,
    MST_DMA      = 2'd2,
    MST_DEBUG    = 2'd3
  } master_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic accFire;
    logic accAllow;
    logic cfgFire;
    logic cfgCommit;
    logic clearAll;
  } strobe_t;

endpackage

// File: rtl/xo_ctrl.sv
module xo_ctrl
  import xo_pkg::*;
(
  input  logic       accValid,
  input  logic [1:0] accMaster,
  input  logic [1:0] accOp,
  input  logic       accHit,
  input  logic       cfgValid,
  input  logic       cfgLive,
  input  logic       cfgGrowOk,
  input  logic       regressEvt,
  input  logic       preserveKeep,
  output strobe_t    strobes
);

  master_e masterKind;
  op_e     opKind;
  logic    fetchRead;
  logic    wipe;

  always_comb begin
    masterKind = master_e'(accMaster);
    opKind     = op_e'(accOp);
    fetchRead  = (masterKind == MST_FETCH) && (opKind == OP_READ);
    wipe       = regressEvt && !preserveKeep;

    strobes.accFire   = accValid;
    strobes.accAllow  = !accHit || fetchRead;
    strobes.cfgFire   = cfgValid;
    strobes.cfgCommit = cfgValid && !wipe && (!cfgLive || cfgGrowOk);
    strobes.clearAll  = wipe;
  end

endmodule

// File: rtl/xo_datapath.sv
module xo_datapath
  import xo_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 2,
  parameter int GRAN_W    = 3,
  parameter int BANK_W    = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        accAddr,
  input  logic [BANK_W-1:0]        accBank,
  input  logic [DATA_W-1:0]        accRdata,
  input  logic [BANK_W-1:0]        cfgBank,
  input  logic [ADDR_W-GRAN_W-1:0] cfgStart,
  input  logic [ADDR_W-GRAN_W-1:0] cfgEnd,
  input  strobe_t                  strobes,
  output logic                     accHit,
  output logic                     cfgLive,
  output logic                     cfgGrowOk,
  output logic                     rspValid,
  output logic                     rspAllow,
  output logic                     rspViolation,
  output logic [DATA_W-1:0]        rspRdata,
  output logic                     cfgDone,
  output logic                     cfgOk
);

  localparam int GAW = ADDR_W - GRAN_W;
  localparam logic [GAW-1:0]  EMPTY_START = '1;
  localparam logic [GAW-1:0]  EMPTY_END   = '0;
  localparam logic [BANK_W:0] BANK_COUNT  = (BANK_W+1)'(NUM_BANKS);

  logic [GAW-1:0]    regStart [NUM_BANKS];
  logic [GAW-1:0]    regEnd   [NUM_BANKS];
  logic [NUM_BANKS-1:0] live;
  logic [NUM_BANKS-1:0] hitVec;
  logic [ADDR_W-1:0] accGran;
  logic              accBankOk;
  logic              cfgBankOk;

  assign accGran   = accAddr >> GRAN_W;
  assign accBankOk = {1'b0, accBank} < BANK_COUNT;
  assign cfgBankOk = {1'b0, cfgBank} < BANK_COUNT;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_region
    localparam logic [BANK_W-1:0] IDX = BANK_W'(i);

    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearAll) begin
        regStart[i] <= EMPTY_START;
        regEnd[i]   <= EMPTY_END;
      end else if (strobes.cfgCommit && cfgBank == IDX) begin
        regStart[i] <= cfgStart;
        regEnd[i]   <= cfgEnd;
      end
    end

    assign live[i]   = regStart[i] <= regEnd[i];
    assign hitVec[i] = live[i]
                    && (accGran >= {{GRAN_W{1'b0}}, regStart[i]})
                    && (accGran <= {{GRAN_W{1'b0}}, regEnd[i]});
  end

  always_comb begin
    accHit    = 1'b0;
    cfgLive   = 1'b0;
    cfgGrowOk = 1'b0;
    if (accBankOk) accHit = hitVec[accBank];
    if (cfgBankOk) begin
      cfgLive   = live[cfgBank];
      cfgGrowOk = (cfgStart <= regStart[cfgBank]) && (cfgEnd >= regEnd[cfgBank]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspAllow     <= 1'b0;
      rspViolation <= 1'b0;
      rspRdata     <= '0;
      cfgDone      <= 1'b0;
      cfgOk        <= 1'b0;
    end else begin
      rspValid     <= strobes.accFire;
      rspAllow     <= strobes.accFire && strobes.accAllow;
      rspViolation <= strobes.accFire && !strobes.accAllow;
      rspRdata     <= (strobes.accFire && strobes.accAllow) ? accRdata : '0;
      cfgDone      <= strobes.cfgFire;
      cfgOk        <= strobes.cfgCommit;
    end
  end

endmodule

// File: rtl/xo_region_filter.sv
module xo_region_filter
  import xo_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 2,
  parameter int GRAN_BYTES = 8,
  localparam int GRAN_W    = $clog2(GRAN_BYTES),
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int GAW       = ADDR_W - GRAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [BANK_W-1:0] accBank,
  input  logic [1:0]        accMaster,
  input  logic [1:0]        accOp,
  input  logic [DATA_W-1:0] accRdata,
  output logic              rspValid,
  output logic              rspAllow,
  output logic              rspViolation,
  output logic [DATA_W-1:0] rspRdata,
  input  logic              cfgValid,
  input  logic [BANK_W-1:0] cfgBank,
  input  logic [GAW-1:0]    cfgStart,
  input  logic [GAW-1:0]    cfgEnd,
  output logic              cfgDone,
  output logic              cfgOk,
  input  logic              regressEvt,
  input  logic              preserveKeep
);

  strobe_t strobes;
  logic    accHit;
  logic    cfgLive;
  logic    cfgGrowOk;

  xo_ctrl ctrl_i (
    .accValid     (accValid),
    .accMaster    (accMaster),
    .accOp        (accOp),
    .accHit       (accHit),
    .cfgValid     (cfgValid),
    .cfgLive      (cfgLive),
    .cfgGrowOk    (cfgGrowOk),
    .regressEvt   (regressEvt),
    .preserveKeep (preserveKeep),
    .strobes      (strobes)
  );

  xo_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .GRAN_W    (GRAN_W),
    .BANK_W    (BANK_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .accAddr      (accAddr),
    .accBank      (accBank),
    .accRdata     (accRdata),
    .cfgBank      (cfgBank),
    .cfgStart     (cfgStart),
    .cfgEnd       (cfgEnd),
    .strobes      (strobes),
    .accHit       (accHit),
    .cfgLive      (cfgLive),
    .cfgGrowOk    (cfgGrowOk),
    .rspValid     (rspValid),
    .rspAllow     (rspAllow),
    .rspViolation (rspViolation),
    .rspRdata     (rspRdata),
    .cfgDone      (cfgDone),
    .cfgOk        (cfgOk)
  );

endmodule

// File: rtl/xo_filter_checker.sv
module xo_filter_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [1:0]        accMaster,
  input logic [1:0]        accOp,
  input logic              rspValid,
  input logic              rspAllow,
  input logic              rspViolation,
  input logic [DATA_W-1:0] rspRdata,
  input logic              cfgValid,
  input logic              cfgDone,
  input logic              cfgOk,
  input logic              regressEvt,
  input logic              preserveKeep
);

  assert_resp_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> rspValid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!rspValid && !rspAllow && !rspViolation && rspRdata == '0));

  assert_fetch_read_allowed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accMaster == 2'd0 && accOp == 2'd0) |=> (rspAllow && !rspViolation));

  assert_deny_blanks_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAllow) |-> (rspViolation && rspRdata == '0));

  assert_violation_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspViolation |-> (rspValid && !rspAllow));

  assert_cfg_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgDone);

  assert_ok_needs_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgOk |-> cfgDone);

  assert_regress_drops_cfg_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && regressEvt && !preserveKeep) |=> !cfgOk);

endmodule

bind xo_region_filter xo_filter_checker #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/xo_region_filter_tb_top.sv
`timescale 1ns/1ps
module xo_region_filter_tb_top;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int GAW    = ADDR_W - 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic [0:0]        accBank = '0;
  logic [1:0]        accMaster = '0;
  logic [1:0]        accOp = '0;
  logic [DATA_W-1:0] accRdata = '0;
  logic              rspValid, rspAllow, rspViolation, cfgDone, cfgOk;
  logic [DATA_W-1:0] rspRdata;
  logic              cfgValid = 1'b0;
  logic [0:0]        cfgBank = '0;
  logic [GAW-1:0]    cfgStart = '0;
  logic [GAW-1:0]    cfgEnd = '0;
  logic              regressEvt = 1'b0;
  logic              preserveKeep = 1'b0;

  int total = 0;
  int fails = 0;

  // behavioural model: bounds per bank, unconfigured = start > end
  int mStart [2];
  int mEnd   [2];

  always #4 clk = ~clk;

  xo_region_filter dut_i (.*);

  task automatic check(input string tag, input logic [4:0] actF, input logic [4:0] expF,
                       input logic [DATA_W-1:0] actD, input logic [DATA_W-1:0] expD);
    total++;
    if (actF !== expF || actD !== expD) begin
      fails++;
      $display("FAIL %s flags=%b/data=%h expected flags=%b/data=%h", tag, actF, actD, expF, expD);
    end
  endtask

  task automatic modelClear();
    for (int b = 0; b < 2; b++) begin
      mStart[b] = (1 << GAW) - 1;
      mEnd[b]   = 0;
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic av, input int addr, input int bank, input int mst, input int op,
                     input logic cv, input int cb, input int cs, input int ce,
                     input logic rg, input logic pk, input string tag);
    logic [DATA_W-1:0] raw;
    logic [4:0] expF;
    logic [DATA_W-1:0] expD;
    bit hit, allow, live, ok;
    raw = $urandom;
    accValid = av; accAddr = ADDR_W'(addr); accBank = 1'(bank);
    accMaster = 2'(mst); accOp = 2'(op); accRdata = raw;
    cfgValid = cv; cfgBank = 1'(cb); cfgStart = GAW'(cs); cfgEnd = GAW'(ce);
    regressEvt = rg; preserveKeep = pk;
    @(posedge clk);
    hit = (mStart[bank] <= mEnd[bank]) && ((addr / 8) >= mStart[bank]) && ((addr / 8) <= mEnd[bank]);
    allow = !hit || (mst == 0 && op == 0);
    ok = 0;
    if (rg && !pk) modelClear();
    else if (cv) begin
      live = mStart[cb] <= mEnd[cb];
      ok = !live || (cs <= mStart[cb] && ce >= mEnd[cb]);
      if (ok) begin mStart[cb] = cs; mEnd[cb] = ce; end
    end
    expF = {av, av && allow, av && !allow, cv, ok};
    expD = (av && allow) ? raw : '0;
    @(negedge clk);
    check(tag, {rspValid, rspAllow, rspViolation, cfgDone, cfgOk}, expF, rspRdata, expD);
  endtask

  task automatic acc(input int addr, input int bank, input int mst, input int op, input string tag);
    cyc(1, addr, bank, mst, op, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(input int cb, input int cs, input int ce, input string tag);
    cyc(0, 0, 0, 0, 0, 1, cb, cs, ce, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : stim
    modelClear();
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {rspValid, rspAllow, rspViolation, cfgDone, cfgOk}, 5'b0, rspRdata, '0);
    rstN = 1'b1;
    acc('h100, 0, 1, 0, "R10 no live region after reset");
    acc('h100, 0, 2, 1, "R1 miss allowed");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle quiet");
    cfg(0, 'h40, 'h4F, "R7 first config accepted");
    acc('h200, 0, 0, 0, "R2 fetch read inside");
    acc('h27F, 0, 1, 0, "R3 cpu data read denied at end bound");
    acc('h200, 0, 2, 0, "R2 dma denied");
    acc('h240, 0, 3, 0, "R2 debug read denied");
    acc('h240, 0, 1, 1, "R2 write denied");
    acc('h240, 0, 1, 2, "R2 erase denied");
    acc('h240, 0, 0, 1, "R2 fetch write denied");
    acc('h240, 0, 0, 3, "R2 reserved op denied");
    acc('h1FF, 0, 1, 0, "R5 below start allowed");
    acc('h280, 0, 2, 0, "R5 above end allowed");
    acc('h205, 0, 1, 0, "R5 low bits ignored at start");
    acc('h240, 1, 1, 0, "R4 other bank unaffected");
    cfg(0, 'h41, 'h4F, "R8 shrink start rejected");
    acc('h200, 0, 1, 0, "R8 region unchanged after reject");
    cfg(0, 'h40, 'h4E, "R8 shrink end rejected");
    acc('h278, 0, 1, 0, "R8 end kept after reject");
    cfg(0, 'h3F, 'h50, "R8 growth accepted");
    acc('h1F8, 0, 1, 0, "R8 grown start denies");
    acc('h287, 0, 3, 0, "R8 grown end denies");
    cfg(1, 'h10, 'h05, "R6 disabled bounds accepted");
    acc('h40, 1, 1, 0, "R6 disabled matches nothing");
    acc('h18, 1, 2, 1, "R6 disabled matches nothing");
    cfg(1, 'h20, 'h20, "R7 config after disabled accepted");
    acc('h100, 1, 1, 0, "R5 single granule denied");
    acc('h107, 1, 2, 0, "R5 single granule last byte denied");
    acc('h108, 1, 1, 0, "R5 next granule allowed");
    acc('h0FF, 1, 1, 0, "R5 previous granule allowed");
    cyc(1, 'h200, 0, 1, 0, 0, 0, 0, 0, 1, 1, "R9 preserve keeps region");
    acc('h200, 0, 1, 0, "R9 region still live");
    cyc(1, 'h200, 0, 1, 0, 1, 1, 'h00, 'h7F, 1, 0, "R9 regression drops config");
    acc('h200, 0, 1, 0, "R9 cleared bank0");
    acc('h100, 1, 3, 2, "R9 cleared bank1");
    for (int i = 0; i < 400; i++) begin
      int s;
      bit cv, rg;
      s  = $urandom_range(0, 'h7F);
      cv = ($urandom_range(0, 7) == 0);
      rg = ($urandom_range(0, 40) == 0);
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 'h3FF), $urandom_range(0, 1),
          $urandom_range(0, 3), $urandom_range(0, 3),
          cv, $urandom_range(0, 1), s, s + $urandom_range(0, 'h10) - 2,
          rg, $urandom_range(0, 1), "R2 mixed random");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule